// File: doc/BRIEF.md
# Oscillator Tuning Word Decoder

This block converts a binary tuning word for a two-stage digitally controlled ring oscillator into the enable lines that set the oscillator's period. The upper part of the word picks one delay-chain path through a one-hot select bus. The lower part sets how many switchable load units are turned on, across two banks. Each bank gets a thermometer code, so raising the code never turns off a unit that was already on.

The chain step, the large-bank unit and the small-bank unit are scaled by powers of two. Because of that scaling, the split needs no arithmetic: each field is a plain bit slice of the word. The decoded enables are held in registers. They take a new value only on a rising clock edge while the update strobe is high, so the oscillator never sees a partly changed code.

A debug output rebuilds the effective delay count from the registered enables. It is the selected path index times 256, plus 32 times the large-bank count, plus the small-bank count. A checker uses it to confirm that the decoded period tracks the code linearly.

Top module: `dcw_decoder_top`

## Requirements
- R1: The coarse field is `code_i[14:8]` and the fine field is `code_i[7:0]`. Within the fine field, `code_i[4:0]` is the small-bank count N1 and `code_i[7:5]` is the large-bank count N2.
- R2: `path_sel_o` always has exactly one bit set. For coarse value k it is bit k, and bit 0 is the shortest path.
- R3: `bank1_en_o` is a thermometer code with its lowest N1 bits set and all other bits clear. Bit 31 is therefore never set.
- R4: `bank2_en_o` is a thermometer code with its lowest N2 bits set and all other bits clear.
- R5: The outputs take the decode of `code_i` on the first rising edge at which `update_i` is high, one cycle of latency. On any edge with `update_i` low, the outputs keep their value whatever `code_i` does.
- R6: Synchronous active-high reset sets `path_sel_o` to bit 0 only and clears both banks, so `delay_cnt_o` reads 0. Reset takes priority over a simultaneous update.
- R7: `delay_cnt_o` equals (index of the set select bit)·256 + (set bits of bank 2)·32 + (set bits of bank 1). After an update this is the sampled code.
- R8: Over codes 0 to 0x7FFF, the effective delay count rises strictly with each increment of the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| update_i | input | 1 | Update strobe; samples `code_i` |
| code_i | input | 15 | Binary tuning word |
| path_sel_o | output | 128 | One-hot delay-chain path select |
| bank1_en_o | output | 32 | Small-step load bank thermometer enable |
| bank2_en_o | output | 7 | Large-step load bank thermometer enable |
| delay_cnt_o | output | 15 | Effective delay count rebuilt from the enables |

## Verification
Reset and the update strobe can arrive in the same cycle. The bench provokes this by raising both together with a nonzero code, and the result is judged correct only if the outputs show the reset state with path 0 and no units on. Back-to-back updates with different codes also overlap with the hold behaviour. These are checked by changing `code_i` while the strobe is low and confirming that every output keeps its last decoded value. A full sweep of all codes then checks one-hot, thermometer shape, the delay-count identity and strict growth.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
    localparam int CODE_W   = 15;
    localparam int FINE_W   = 8;
    localparam int B1_W     = 5;
    localparam int COARSE_W = CODE_W - FINE_W;
    localparam int B2_W     = FINE_W - B1_W;
    localparam int PATHS    = 1 << COARSE_W;
    localparam int B1_UNITS = 1 << B1_W;
    localparam int B2_UNITS = (1 << B2_W) - 1;

    typedef struct packed {
        logic [PATHS-1:0]    path_sel;
        logic [B1_UNITS-1:0] bank1_en;
        logic [B2_UNITS-1:0] bank2_en;
    } dcw_enables_t;

    function automatic logic is_therm(input logic [B1_UNITS-1:0] v);
        return ((v & (v + 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/dcw_coarse_dec.sv
module dcw_coarse_dec #(
    parameter int SEL_W = 7,
    localparam int N_OUT = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [N_OUT-1:0] onehot_o
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_line
        assign onehot_o[i] = (sel_i == SEL_W'(i));
    end
endmodule

// File: rtl/dcw_therm_enc.sv
module dcw_therm_enc #(
    parameter int VAL_W = 5,
    parameter int UNITS = 32
) (
    input  logic [VAL_W-1:0] val_i,
    output logic [UNITS-1:0] therm_o
);
    for (genvar i = 0; i < UNITS; i++) begin : g_unit
        assign therm_o[i] = ({{(32-VAL_W){1'b0}}, val_i} > 32'(i));
    end
endmodule

// File: rtl/dcw_delay_count.sv
module dcw_delay_count #(
    parameter int CODE_W   = 15,
    parameter int FINE_W   = 8,
    parameter int B1_W     = 5,
    parameter int PATHS    = 128,
    parameter int B1_UNITS = 32,
    parameter int B2_UNITS = 7
) (
    input  logic [PATHS-1:0]    path_sel_i,
    input  logic [B1_UNITS-1:0] bank1_en_i,
    input  logic [B2_UNITS-1:0] bank2_en_i,
    output logic [CODE_W-1:0]   count_o
);
    logic [CODE_W-1:0] idx, n1, n2;

    always_comb begin
        idx = '0;
        for (int i = 0; i < PATHS; i++)
            if (path_sel_i[i]) idx = idx | CODE_W'(i);
        n1 = '0;
        for (int i = 0; i < B1_UNITS; i++)
            n1 = n1 + CODE_W'(bank1_en_i[i]);
        n2 = '0;
        for (int i = 0; i < B2_UNITS; i++)
            n2 = n2 + CODE_W'(bank2_en_i[i]);
        count_o = (idx << FINE_W) + (n2 << B1_W) + n1;
    end
endmodule

// File: rtl/dcw_decoder_top.sv
module dcw_decoder_top
    import dcw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                update_i,
    input  logic [CODE_W-1:0]   code_i,
    output logic [PATHS-1:0]    path_sel_o,
    output logic [B1_UNITS-1:0] bank1_en_o,
    output logic [B2_UNITS-1:0] bank2_en_o,
    output logic [CODE_W-1:0]   delay_cnt_o
);
    dcw_enables_t dec_next, dec_q;

    // R1: plain bit split of the tuning word
    dcw_coarse_dec #(.SEL_W(COARSE_W)) u_coarse (
        .sel_i   (code_i[CODE_W-1:FINE_W]),
        .onehot_o(dec_next.path_sel)
    );

    dcw_therm_enc #(.VAL_W(B1_W), .UNITS(B1_UNITS)) u_bank1 (
        .val_i  (code_i[B1_W-1:0]),
        .therm_o(dec_next.bank1_en)
    );

    dcw_therm_enc #(.VAL_W(B2_W), .UNITS(B2_UNITS)) u_bank2 (
        .val_i  (code_i[FINE_W-1:B1_W]),
        .therm_o(dec_next.bank2_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q          <= '0;
            dec_q.path_sel <= PATHS'(1);
        end else if (update_i) begin
            dec_q <= dec_next;
        end
    end

    assign path_sel_o = dec_q.path_sel;
    assign bank1_en_o = dec_q.bank1_en;
    assign bank2_en_o = dec_q.bank2_en;

    dcw_delay_count #(
        .CODE_W(CODE_W), .FINE_W(FINE_W), .B1_W(B1_W),
        .PATHS(PATHS), .B1_UNITS(B1_UNITS), .B2_UNITS(B2_UNITS)
    ) u_count (
        .path_sel_i(dec_q.path_sel),
        .bank1_en_i(dec_q.bank1_en),
        .bank2_en_i(dec_q.bank2_en),
        .count_o   (delay_cnt_o)
    );

    AST_PATH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(path_sel_o) == 1);  // R2
    AST_BANK1_THERM: assert property (@(posedge clk) disable iff (rst)
        is_therm(bank1_en_o) && !bank1_en_o[B1_UNITS-1]);  // R3
    AST_BANK2_THERM: assert property (@(posedge clk) disable iff (rst)
        is_therm(B1_UNITS'(bank2_en_o)));  // R4
    AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !update_i |=> $stable(path_sel_o) && $stable(bank1_en_o) && $stable(bank2_en_o));  // R5
    AST_COUNT_TRACKS_CODE: assert property (@(posedge clk) disable iff (rst)
        update_i |=> delay_cnt_o == $past(code_i));  // R7
endmodule

// File: tb/dcw_decoder_top_tb.sv
module dcw_decoder_top_tb;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          update_i = 1'b0;
    logic [14:0]   code_i = '0;
    logic [127:0]  path_sel_o;
    logic [31:0]   bank1_en_o;
    logic [6:0]    bank2_en_o;
    logic [14:0]   delay_cnt_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dcw_decoder_top u_dut (
        .clk(clk), .rst(rst), .update_i(update_i), .code_i(code_i),
        .path_sel_o(path_sel_o), .bank1_en_o(bank1_en_o),
        .bank2_en_o(bank2_en_o), .delay_cnt_o(delay_cnt_o)
    );

    function automatic logic [127:0] exp_path(input logic [14:0] c);
        return 128'd1 << c[14:8];
    endfunction
    function automatic logic [31:0] exp_b1(input logic [14:0] c);
        return (32'd1 << c[4:0]) - 32'd1;
    endfunction
    function automatic logic [6:0] exp_b2(input logic [14:0] c);
        logic [7:0] t;
        t = (8'd1 << c[7:5]) - 8'd1;
        return t[6:0];
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [14:0] c);
        chk({"R2 ", tag}, path_sel_o, exp_path(c));
        chk({"R3 ", tag}, 128'(bank1_en_o), 128'(exp_b1(c)));
        chk({"R4 ", tag}, 128'(bank2_en_o), 128'(exp_b2(c)));
        chk({"R7 ", tag}, 128'(delay_cnt_o), 128'(c));
    endtask

    // drive at negedge, sample at following negedge (after one posedge)
    task automatic load(input logic [14:0] c);
        @(negedge clk);
        code_i = c;
        update_i = 1'b1;
        @(negedge clk);
        update_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [14:0] prev_cnt;
        logic [14:0] held;
        void'($urandom(32'h5eed));

        // R6: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R6 reset path", path_sel_o, 128'd1);
        chk("R6 reset bank1", 128'(bank1_en_o), 128'd0);
        chk("R6 reset bank2", 128'(bank2_en_o), 128'd0);
        chk("R6 reset count", 128'(delay_cnt_o), 128'd0);

        // R1/R2/R3/R4 directed corners
        load(15'h7FFF); chk_all("R1 max code", 15'h7FFF);
        load(15'h001F); chk_all("R1 bank1 full", 15'h001F);
        load(15'h00E0); chk_all("R1 bank2 full", 15'h00E0);
        load(15'h0100); chk_all("R1 first coarse step", 15'h0100);
        load(15'h00FF); chk_all("R1 fine max", 15'h00FF);

        // R5: hold while strobe low
        held = 15'h00FF;
        @(negedge clk);
        code_i = 15'h5A5A;
        @(negedge clk);
        @(negedge clk);
        chk_all("R5 hold", held);

        // R5: back-to-back updates
        @(negedge clk);
        code_i = 15'h1234; update_i = 1'b1;
        @(negedge clk);
        chk_all("R5 b2b first", 15'h1234);
        code_i = 15'h4321;
        @(negedge clk);
        update_i = 1'b0;
        chk_all("R5 b2b second", 15'h4321);

        // R6: reset wins over update
        @(negedge clk);
        rst = 1'b1; update_i = 1'b1; code_i = 15'h3ABC;
        @(negedge clk);
        rst = 1'b0; update_i = 1'b0;
        chk("R6 reset over update", path_sel_o, 128'd1);
        chk("R6 reset over update count", 128'(delay_cnt_o), 128'd0);

        // random codes
        for (int i = 0; i < 2000; i++) begin
            logic [14:0] c;
            c = 15'($urandom);
            load(c);
            chk_all("R5 random", c);
        end

        // R8: full sweep, strictly increasing count
        load(15'h0000);
        chk_all("R8 sweep", 15'h0000);
        prev_cnt = delay_cnt_o;
        for (int c = 1; c < 32768; c++) begin
            load(15'(c));
            chk_all("R8 sweep", 15'(c));
            n_checks++;
            if (!(delay_cnt_o > prev_cnt)) begin
                n_fails++;
                $display("FAIL R8 monotonic actual=%0d expected>%0d", delay_cnt_o, prev_cnt);
            end
            prev_cnt = delay_cnt_o;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule